// File: doc/BRIEF.md
# DMA Transfer Arbiter and Sequencer

This block is the service engine of a multi-channel DMA controller. On each service tick it picks one or more of its channels by priority and carries out one byte or one word transfer for each channel it picks. It then moves that channel's memory address forward, counts the channel's transfer count down, and decides from the channel's transfer kind whether the channel stops. Register decode lives outside the block. The surrounding logic drives the command bits, the channel masks and the per-channel mode words directly. It loads a channel's current address and count through a single load port.

Each transfer has a bus-clock cost, and the costs add up in an internal accumulator. While that accumulator is nonzero, a tick only drains a fixed amount from it, so the engine cannot start transfers faster than the bus could carry them. Each transfer appears on a per-channel strobe with its address, direction code and width. Acknowledge pulses and sticky terminal-count flags are also per channel.

Top module: `dma_xfer_sequencer`

## Requirements
- R1: The engine is active only while `cmd_disable` is 0 and at least one `mask` bit is 0. While it is inactive, no transfer happens, the cost accumulator reads 0, the setup state and the scan start are cleared, and the next transfer is again treated as the first after idle.
- R2: A channel is eligible when its captured hardware request or its software request is set and its `mask` bit is 0. A masked channel is never served, even when it requests.
- R3: When `cmd_rotate` is 0, the scan always starts at channel 0. When it is 1, the scan start moves up by one, wrapping after the last channel, on every working tick. A working tick is a tick with the engine active and the cost at 0.
- R4: When `cmd_hold` is 0, a working tick serves only the first eligible channel in scan order. When it is 1, it serves every eligible channel in the same tick.
- R5: A working tick that serves n channels sets the cost to n×5 when `cmd_fast` is 1, or n×7 when it is 0. The first working tick that serves anything after the engine has been idle adds 2 more.
- R6: A tick that arrives with a nonzero cost subtracts 3 from it, stopping at 0, and performs no transfer.
- R7: A served channel's address moves up by 1 for a byte transfer and by 2 for a word transfer. With `wrap_en` set, only bits 23:0 advance and bits 31:24 stay fixed. With it clear, the carry propagates into the whole address.
- R8: The count drops by 1 on every transfer. The transfer made while the count is 0 is the last one: it sets the channel's `tc` flag, pulses `ack`, and clears the channel's hardware and software requests. A channel loaded with count N therefore makes N+1 transfers.
- R9: An `eop` input that is high while its channel is served ends the channel in demand and block kinds: `ack` pulses, both requests are cleared, and `tc` stays 0. In single kind `eop` has no effect.
- R10: Mode word per channel (5 bits, at `mode[5i+4:5i]`): bits 4:3 give the kind (00 demand, 01 single, 10 block, 11 cascade), bits 2:1 give the direction (00 verify, 01 device to memory, 10 memory to device, 11 memory to memory), and bit 0 selects word width. In demand kind the channel keeps transferring while its hardware request is held. If it is served without a hardware request (software request only), it transfers once with no `ack` and its software request is cleared.
- R11: In single kind every transfer pulses `ack` and clears both of the channel's requests, so the channel transfers again only after a new rising edge or a new software request.
- R12: In block kind the channel keeps its requests and pulses `ack` on every transfer until terminal count or `eop`. Each transfer strobe reports the pre-increment address, the direction code and the width bit of its channel.
- R13: A rising edge on `drq[i]` sets the channel's hardware request and a falling edge clears it. A `sreq_set[i]` pulse sets the software request. A load on the load port writes the address and count of channel `ld_ch` and clears its `tc` flag.
- R14: A channel in cascade kind, or with direction code 11, is never served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Service tick, one cycle pulse |
| cmd_disable | input | 1 | Engine disable |
| cmd_fast | input | 1 | Short transfer cycle (5 clocks instead of 7) |
| cmd_rotate | input | 1 | Rotating priority enable |
| cmd_hold | input | 1 | Serve all eligible channels in one tick |
| wrap_en | input | 1 | Keep address bits 31:24 fixed on increment |
| mask | input | NCH | Per-channel mask, 1 = masked |
| mode | input | NCH*5 | Per-channel mode words |
| drq | input | NCH | Hardware request lines (edge captured) |
| sreq_set | input | NCH | Software request set pulses |
| eop | input | NCH | End-of-process inputs |
| ld_valid | input | 1 | Load strobe |
| ld_ch | input | CW | Channel to load |
| ld_addr | input | AW | Address to load |
| ld_count | input | CNT_W | Count to load |
| xfer_valid | output | NCH | Per-channel transfer strobe |
| xfer_addr | output | NCH*AW | Address used by each strobed transfer |
| xfer_dir | output | NCH*2 | Direction code of each strobed transfer |
| xfer_word | output | NCH | Width bit of each strobed transfer |
| ack | output | NCH | Acknowledge pulse |
| tc | output | NCH | Sticky terminal-count flags |
| cost | output | COST_W | Accumulated bus-clock cost |

## Verification
The hardest behaviour to reach from the ports is the interaction between the cost accumulator and the scheduler. A second transfer only happens after the cost from the first has fully drained. The setup surcharge reappears only after the engine has been idle. The stimulus therefore drains the accumulator tick by tick, counting the ticks, before every check that expects a transfer, and it switches the engine off and on again to bring back the first-after-idle cost. The address sweep crosses the 24-bit boundary with and without wrap, for both widths. Terminal count is reached by loading a small count and walking a channel through exactly N+1 transfers.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        KIND_DEMAND  = 2'b00,
        KIND_SINGLE  = 2'b01,
        KIND_BLOCK   = 2'b10,
        KIND_CASCADE = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        DIR_VERIFY  = 2'b00,
        DIR_TO_MEM  = 2'b01,
        DIR_TO_DEV  = 2'b10,
        DIR_MEM_MEM = 2'b11
    } xfer_dir_e;

    typedef struct packed {
        xfer_kind_e kind;
        xfer_dir_e  dir;
        logic       word;
    } chan_mode_t;

    localparam int MODE_W = $bits(chan_mode_t);

    typedef struct packed {
        logic ack;
        logic set_tc;
        logic clr_req;
        logic clr_sreq;
    } chan_outcome_t;

endpackage

// File: rtl/dma_seq_addr_step.sv
module dma_seq_addr_step #(
    parameter int AW        = 32,
    parameter int WRAP_BITS = 24
) (
    input  logic [AW-1:0] addr_in,
    input  logic          word,
    input  logic          wrap_en,
    output logic [AW-1:0] addr_out
);
    logic [AW-1:0]        inc;
    logic [AW-1:0]        full_sum;
    logic [WRAP_BITS-1:0] low_sum;

    assign inc      = word ? AW'(2) : AW'(1);
    assign full_sum = addr_in + inc;
    assign low_sum  = addr_in[WRAP_BITS-1:0] + inc[WRAP_BITS-1:0];
    assign addr_out = wrap_en ? {addr_in[AW-1:WRAP_BITS], low_sum} : full_sum;
endmodule

// File: rtl/dma_seq_outcome.sv
module dma_seq_outcome
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  chan_mode_t     mode,
    input  logic [CNT_W-1:0] count,
    input  logic           eop,
    input  logic           req_hw,
    output logic [CNT_W-1:0] next_count,
    output chan_outcome_t  res
);
    always_comb begin
        next_count = count - 1'b1;
        res        = '0;
        if (count == '0) begin
            res.ack      = 1'b1;
            res.set_tc   = 1'b1;
            res.clr_req  = 1'b1;
            res.clr_sreq = 1'b1;
        end else if (eop && mode.kind != KIND_SINGLE) begin
            res.ack      = 1'b1;
            res.clr_req  = 1'b1;
            res.clr_sreq = 1'b1;
        end else begin
            case (mode.kind)
                KIND_DEMAND: begin
                    if (req_hw) begin
                        res.ack = 1'b1;
                    end else begin
                        res.clr_sreq = 1'b1;
                    end
                end
                KIND_SINGLE: begin
                    res.ack      = 1'b1;
                    res.clr_req  = 1'b1;
                    res.clr_sreq = 1'b1;
                end
                default: res.ack = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dma_seq_scan.sv
module dma_seq_scan #(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] elig,
    input  logic [CW-1:0]  start,
    input  logic           hold,
    output logic [NCH-1:0] serve
);
    always_comb begin
        logic found;
        serve = '0;
        found = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            int          pos;
            logic [CW-1:0] idx;
            pos = int'(start) + k;
            if (pos >= NCH) pos = pos - NCH;
            idx = CW'(pos);
            if (elig[idx] && (hold || !found)) begin
                serve[idx] = 1'b1;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_xfer_sequencer.sv
module dma_xfer_sequencer
    import dma_seq_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int AW         = 32,
    parameter int WRAP_BITS  = 24,
    parameter int CNT_W      = 16,
    parameter int COST_W     = 8,
    parameter int TICK_DEC   = 3,
    parameter int SETUP_COST = 2,
    parameter int FAST_COST  = 5,
    parameter int SLOW_COST  = 7,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                cmd_disable,
    input  logic                cmd_fast,
    input  logic                cmd_rotate,
    input  logic                cmd_hold,
    input  logic                wrap_en,
    input  logic [NCH-1:0]      mask,
    input  logic [NCH*MODE_W-1:0] mode,
    input  logic [NCH-1:0]      drq,
    input  logic [NCH-1:0]      sreq_set,
    input  logic [NCH-1:0]      eop,
    input  logic                ld_valid,
    input  logic [CW-1:0]       ld_ch,
    input  logic [AW-1:0]       ld_addr,
    input  logic [CNT_W-1:0]    ld_count,
    output logic [NCH-1:0]      xfer_valid,
    output logic [NCH*AW-1:0]   xfer_addr,
    output logic [NCH*2-1:0]    xfer_dir,
    output logic [NCH-1:0]      xfer_word,
    output logic [NCH-1:0]      ack,
    output logic [NCH-1:0]      tc,
    output logic [COST_W-1:0]   cost
);
    typedef struct packed {
        logic [NCH-1:0][AW-1:0]    addr;
        logic [NCH-1:0][CNT_W-1:0] cnt;
        logic [NCH-1:0]            req;
        logic [NCH-1:0]            sreq;
        logic [NCH-1:0]            drq_prev;
        logic [NCH-1:0]            tc;
        logic                      running;
        logic [CW-1:0]             start;
        logic [COST_W-1:0]         cost;
        logic [NCH-1:0]            xv;
        logic [NCH-1:0][AW-1:0]    xa;
        logic [NCH-1:0][1:0]       xdir;
        logic [NCH-1:0]            xword;
        logic [NCH-1:0]            ack;
    } state_t;

    state_t s_q, s_d;

    chan_mode_t        mode_s   [NCH];
    logic [AW-1:0]     step_addr[NCH];
    logic [CNT_W-1:0]  next_cnt [NCH];
    chan_outcome_t     outc     [NCH];
    logic [NCH-1:0]    elig;
    logic [NCH-1:0]    serve;
    logic [NCH-1:0]    ld_hit;
    logic              active;
    logic              work;
    logic [COST_W-1:0] per_cost;
    logic [COST_W-1:0] n_serve;
    logic [COST_W-1:0] cost_new;

    assign active = !cmd_disable && !(&mask);
    assign work   = tick && active && (s_q.cost == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign mode_s[i] = chan_mode_t'(mode[i*MODE_W +: MODE_W]);
        assign ld_hit[i] = ld_valid && (ld_ch == CW'(i));
        assign elig[i]   = (s_q.req[i] || s_q.sreq[i]) && !mask[i]
                           && (mode_s[i].kind != KIND_CASCADE)
                           && (mode_s[i].dir != DIR_MEM_MEM);

        dma_seq_addr_step #(.AW(AW), .WRAP_BITS(WRAP_BITS)) u_step (
            .addr_in (s_q.addr[i]),
            .word    (mode_s[i].word),
            .wrap_en (wrap_en),
            .addr_out(step_addr[i])
        );

        dma_seq_outcome #(.CNT_W(CNT_W)) u_outc (
            .mode      (mode_s[i]),
            .count     (s_q.cnt[i]),
            .eop       (eop[i]),
            .req_hw    (s_q.req[i]),
            .next_count(next_cnt[i]),
            .res       (outc[i])
        );

        // R8: terminal-count flag stays until the channel is reloaded
        assert_tc_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.tc[i] && !ld_hit[i]) |=> s_q.tc[i]);

        // R11: single kind drops both requests after a transfer
        assert_single_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (work && serve[i] && mode_s[i].kind == KIND_SINGLE && !sreq_set[i]
             && !(drq[i] && !s_q.drq_prev[i]))
            |=> (!s_q.req[i] && !s_q.sreq[i]));

        // R7: with wrap enabled the top address bits never move on a transfer
        assert_wrap_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (work && serve[i] && wrap_en && !ld_hit[i])
            |=> (s_q.addr[i][AW-1:WRAP_BITS] == $past(s_q.addr[i][AW-1:WRAP_BITS])));
    end

    dma_seq_scan #(.NCH(NCH)) u_scan (
        .elig (elig),
        .start(s_q.start),
        .hold (cmd_hold),
        .serve(serve)
    );

    assign per_cost = cmd_fast ? COST_W'(FAST_COST) : COST_W'(SLOW_COST);
    assign n_serve  = COST_W'($countones(serve));
    assign cost_new = (n_serve * per_cost)
                    + (((n_serve != '0) && !s_q.running) ? COST_W'(SETUP_COST) : '0);

    always_comb begin
        s_d     = s_q;
        s_d.xv  = '0;
        s_d.ack = '0;

        if (!active) begin
            s_d.cost    = '0;
            s_d.running = 1'b0;
            s_d.start   = '0;
        end else if (tick) begin
            if (s_q.cost != '0) begin
                s_d.cost = (s_q.cost > COST_W'(TICK_DEC)) ? s_q.cost - COST_W'(TICK_DEC) : '0;
            end else begin
                for (int i = 0; i < NCH; i++) begin
                    if (serve[i]) begin
                        s_d.addr[i]  = step_addr[i];
                        s_d.cnt[i]   = next_cnt[i];
                        s_d.xv[i]    = 1'b1;
                        s_d.xa[i]    = s_q.addr[i];
                        s_d.xdir[i]  = mode_s[i].dir;
                        s_d.xword[i] = mode_s[i].word;
                        s_d.ack[i]   = outc[i].ack;
                        if (outc[i].set_tc)   s_d.tc[i]   = 1'b1;
                        if (outc[i].clr_req)  s_d.req[i]  = 1'b0;
                        if (outc[i].clr_sreq) s_d.sreq[i] = 1'b0;
                    end
                end
                s_d.cost = cost_new;
                if (n_serve != '0) s_d.running = 1'b1;
                if (cmd_rotate) begin
                    s_d.start = (s_q.start == CW'(NCH-1)) ? '0 : s_q.start + 1'b1;
                end else begin
                    s_d.start = '0;
                end
            end
        end

        for (int i = 0; i < NCH; i++) begin
            if (drq[i] && !s_q.drq_prev[i]) begin
                s_d.req[i] = 1'b1;
            end else if (!drq[i] && s_q.drq_prev[i]) begin
                s_d.req[i] = 1'b0;
            end
            if (sreq_set[i]) s_d.sreq[i] = 1'b1;
            if (ld_hit[i]) begin
                s_d.addr[i] = ld_addr;
                s_d.cnt[i]  = ld_count;
                s_d.tc[i]   = 1'b0;
            end
        end
        s_d.drq_prev = drq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign xfer_valid = s_q.xv;
    assign xfer_addr  = s_q.xa;
    assign xfer_dir   = s_q.xdir;
    assign xfer_word  = s_q.xword;
    assign ack        = s_q.ack;
    assign tc         = s_q.tc;
    assign cost       = s_q.cost;

    // R1: an inactive engine neither transfers nor keeps a cost
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!active) |=> (s_q.xv == '0 && s_q.cost == '0));

    // R6: a tick that finds cost pending performs no transfer
    assert_drain_no_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.cost != '0) |=> (s_q.xv == '0));

    // R4: without hold at most one channel is picked, and only eligible ones
    assert_single_pick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((serve & ~elig) == '0) && (cmd_hold || $onehot0(serve)));

    // R12: an acknowledge never appears without its transfer strobe
    assert_ack_with_xfer_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.ack & ~s_q.xv) == '0));
endmodule

// File: tb/dma_xfer_sequencer_bench.sv
module dma_xfer_sequencer_bench;
    localparam int NCH = 4;
    localparam int AW  = 32;
    localparam int DEC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic cmd_disable = 1'b0, cmd_fast = 1'b0, cmd_rotate = 1'b0, cmd_hold = 1'b0;
    logic wrap_en = 1'b0;
    logic [NCH-1:0] mask = '0;
    logic [NCH*5-1:0] mode = '0;
    logic [NCH-1:0] drq = '0, sreq_set = '0, eop = '0;
    logic ld_valid = 1'b0;
    logic [1:0] ld_ch = '0;
    logic [AW-1:0] ld_addr = '0;
    logic [15:0] ld_count = '0;
    logic [NCH-1:0] xfer_valid, xfer_word, ack, tc;
    logic [NCH*AW-1:0] xfer_addr;
    logic [NCH*2-1:0] xfer_dir;
    logic [7:0] cost;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_xfer_sequencer u_dma_xfer_sequencer (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmd_disable(cmd_disable), .cmd_fast(cmd_fast), .cmd_rotate(cmd_rotate),
        .cmd_hold(cmd_hold), .wrap_en(wrap_en), .mask(mask), .mode(mode),
        .drq(drq), .sreq_set(sreq_set), .eop(eop),
        .ld_valid(ld_valid), .ld_ch(ld_ch), .ld_addr(ld_addr), .ld_count(ld_count),
        .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_dir(xfer_dir),
        .xfer_word(xfer_word), .ack(ack), .tc(tc), .cost(cost)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic drain(output int n);
        n = 0;
        while (cost != 0 && n < 60) begin
            do_tick();
            n++;
            check("R6 no transfer while draining", 64'(xfer_valid), 64'(0));
        end
    endtask

    task automatic load(input int ch, input logic [AW-1:0] a, input logic [15:0] c);
        @(negedge clk);
        ld_valid = 1'b1; ld_ch = 2'(ch); ld_addr = a; ld_count = c;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic set_mode(input int ch, input logic [1:0] kind, input logic [1:0] dir, input logic w);
        mode[ch*5 +: 5] = {kind, dir, w};
    endtask

    function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a, input bit w, input bit wr);
        logic [AW-1:0] inc;
        inc = w ? 32'd2 : 32'd1;
        if (wr) return {a[31:24], 24'(a[23:0] + inc[23:0])};
        return a + inc;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [AW-1:0] addrs [3];
        addrs[0] = 32'h12FF_FFFF;
        addrs[1] = 32'hA5FF_FFFE;
        addrs[2] = 32'h0000_1000;
        for (int ch = 0; ch < NCH; ch++) set_mode(ch, 2'b10, 2'b01, 1'b0);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("reset xfer_valid", 64'(xfer_valid), 64'(0));
        check("reset tc", 64'(tc), 64'(0));
        check("reset cost", 64'(cost), 64'(0));
        check("reset ack", 64'(ack), 64'(0));

        // R1 / R2: gating and masking
        load(0, 32'h100, 16'h0100);
        cmd_disable = 1'b1;
        step(); drq[0] = 1'b1; step();
        do_tick();
        check("R1 disabled: no transfer", 64'(xfer_valid), 64'(0));
        cmd_disable = 1'b0; mask = 4'hF;
        do_tick();
        check("R1 all masked: no transfer", 64'(xfer_valid), 64'(0));
        check("R1 all masked: cost 0", 64'(cost), 64'(0));
        mask = 4'h1;
        do_tick();
        check("R2 masked requester not served", 64'(xfer_valid), 64'(0));
        mask = 4'h0;

        // R5 / R6 / R7 sweep over width, wrap and cycle speed
        for (int ai = 0; ai < 3; ai++) begin
            for (int c = 0; c < 4; c++) begin
                bit w, wr, f;
                int per;
                logic [AW-1:0] a1;
                w = c[0]; wr = c[1]; f = c[0] ^ c[1];
                per = f ? 5 : 7;
                set_mode(0, 2'b10, 2'b01, w);
                wrap_en = wr; cmd_fast = f;
                @(negedge clk); cmd_disable = 1'b1;
                @(negedge clk); cmd_disable = 1'b0;
                check("R1 cost cleared by disable", 64'(cost), 64'(0));
                load(0, addrs[ai], 16'h0100);
                do_tick();
                check("R7 first address", 64'(xfer_addr[AW-1:0]), 64'(addrs[ai]));
                check("R5 first cost incl setup", 64'(cost), 64'(per + 2));
                check("R12 width bit", 64'(xfer_word[0]), 64'(w));
                drain(n);
                check("R6 drain tick count", 64'(n), 64'((per + 2 + DEC - 1) / DEC));
                do_tick();
                a1 = next_addr(addrs[ai], w, wr);
                check("R7 stepped address", 64'(xfer_addr[AW-1:0]), 64'(a1));
                check("R5 later cost", 64'(cost), 64'(per));
                drain(n);
                check("R6 drain tick count", 64'(n), 64'((per + DEC - 1) / DEC));
            end
        end
        wrap_en = 1'b0; cmd_fast = 1'b0;
        drq[0] = 1'b0; step(); step();

        // R8: terminal count after N+1 transfers, R12 strobe contents
        set_mode(1, 2'b10, 2'b10, 1'b1);
        load(1, 32'h2000, 16'd2);
        drq[1] = 1'b1; step();
        for (int k = 0; k < 3; k++) begin
            do_tick();
            check("R8 transfer strobe ch1", 64'(xfer_valid), 64'(4'b0010));
            check("R12 ack ch1", 64'(ack[1]), 64'(1));
            check("R12 dir ch1", 64'(xfer_dir[3:2]), 64'(2'b10));
            check("R12 address ch1", 64'(xfer_addr[2*AW-1:AW]), 64'(32'h2000 + 2*k));
            check("R8 tc timing", 64'(tc[1]), 64'(k == 2));
            drain(n);
        end
        do_tick();
        check("R8 request cleared at terminal count", 64'(xfer_valid), 64'(0));
        load(1, 32'h2000, 16'd5);
        check("R13 load clears tc", 64'(tc[1]), 64'(0));
        drq[1] = 1'b0; step();

        // R9: end of process
        set_mode(2, 2'b10, 2'b01, 1'b0);
        load(2, 32'h3000, 16'd10);
        eop[2] = 1'b1; drq[2] = 1'b1; step();
        do_tick();
        check("R9 block transfer with eop", 64'(xfer_valid), 64'(4'b0100));
        check("R9 eop ack", 64'(ack[2]), 64'(1));
        check("R9 eop no tc", 64'(tc[2]), 64'(0));
        drain(n);
        do_tick();
        check("R9 block ended by eop", 64'(xfer_valid), 64'(0));
        set_mode(2, 2'b01, 2'b01, 1'b0);
        drq[2] = 1'b0; step(); drq[2] = 1'b1; step();
        do_tick();
        check("R9 single ignores eop: transfer", 64'(xfer_valid), 64'(4'b0100));
        check("R9 single ignores eop: ack", 64'(ack[2]), 64'(1));
        check("R9 single ignores eop: no tc", 64'(tc[2]), 64'(0));
        drain(n);
        eop[2] = 1'b0; drq[2] = 1'b0; step();

        // R10: demand kind
        set_mode(0, 2'b00, 2'b01, 1'b0);
        load(0, 32'h4000, 16'd20);
        drq[0] = 1'b1; step();
        do_tick();
        check("R10 demand transfer", 64'(xfer_valid), 64'(4'b0001));
        check("R10 demand ack", 64'(ack[0]), 64'(1));
        drain(n);
        do_tick();
        check("R10 demand continues while held", 64'(xfer_valid), 64'(4'b0001));
        drain(n);
        drq[0] = 1'b0; step();
        do_tick();
        check("R13 falling edge clears request", 64'(xfer_valid), 64'(0));
        @(negedge clk); sreq_set[0] = 1'b1;
        @(negedge clk); sreq_set[0] = 1'b0;
        do_tick();
        check("R10 demand soft request transfers", 64'(xfer_valid), 64'(4'b0001));
        check("R10 demand without line: no ack", 64'(ack[0]), 64'(0));
        drain(n);
        do_tick();
        check("R10 demand soft request consumed", 64'(xfer_valid), 64'(0));

        // R11: single kind
        set_mode(3, 2'b01, 2'b10, 1'b1);
        load(3, 32'h5000, 16'd20);
        drq[3] = 1'b1; step();
        do_tick();
        check("R11 single transfer", 64'(xfer_valid), 64'(4'b1000));
        check("R11 single ack", 64'(ack[3]), 64'(1));
        drain(n);
        do_tick();
        check("R11 single stops despite held line", 64'(xfer_valid), 64'(0));
        @(negedge clk); sreq_set[3] = 1'b1;
        @(negedge clk); sreq_set[3] = 1'b0;
        do_tick();
        check("R11 soft request transfer", 64'(xfer_valid), 64'(4'b1000));
        drain(n);
        do_tick();
        check("R11 soft request cleared", 64'(xfer_valid), 64'(0));
        drq[3] = 1'b0; step();

        // R14: cascade and memory-to-memory never served
        set_mode(3, 2'b11, 2'b01, 1'b0);
        drq[3] = 1'b1; step();
        do_tick();
        check("R14 cascade not served", 64'(xfer_valid), 64'(0));
        set_mode(3, 2'b10, 2'b11, 1'b0);
        do_tick();
        check("R14 mem-to-mem not served", 64'(xfer_valid), 64'(0));
        check("R14 no cost", 64'(cost), 64'(0));
        drq[3] = 1'b0; step();

        // R3 / R4: priority, rotation, hold
        for (int ch = 0; ch < NCH; ch++) begin
            set_mode(ch, 2'b10, 2'b01, 1'b0);
            load(ch, 32'h6000 + 32'(ch) * 32'h100, 16'd100);
        end
        drq = 4'hF; step();
        for (int k = 0; k < 3; k++) begin
            do_tick();
            check("R3 fixed priority ch0", 64'(xfer_valid), 64'(4'b0001));
            drain(n);
        end
        cmd_rotate = 1'b1;
        for (int k = 0; k < 6; k++) begin
            do_tick();
            check("R3 rotating priority", 64'(xfer_valid), 64'(4'b0001 << (k % 4)));
            drain(n);
        end
        cmd_rotate = 1'b0;
        cmd_hold = 1'b1;
        do_tick();
        check("R4 hold serves all", 64'(xfer_valid), 64'(4'hF));
        check("R5 cost of four transfers", 64'(cost), 64'(28));
        drain(n);
        check("R6 drain of 28", 64'(n), 64'(10));
        mask = 4'b0100;
        do_tick();
        check("R2 hold skips masked channel", 64'(xfer_valid), 64'(4'b1011));
        check("R5 cost of three transfers", 64'(cost), 64'(21));
        drain(n);
        cmd_hold = 1'b0; mask = 4'b0001;
        do_tick();
        check("R4 no hold serves first unmasked", 64'(xfer_valid), 64'(4'b0010));

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule